// File: doc/BRIEF.md
# Buffered Serial Transmitter with Status Flags

This block turns bytes written by software into asynchronous serial frames on a single output line. It has a one-byte holding register in front of a shift register. Software can queue the next byte while the current one is still going out. Two registers are decoded: a control/status register and a transmit-data register. The control/status register holds the enable bit and the parity selection. It also returns two read-only flags: one for an empty holding register and one for a finished frame.

A frame is a low start bit, the data bits least significant first, an optional parity bit and one high stop bit. Each bit lasts from one pulse of the bit-rate enable input to the next. The bit-rate enable comes from outside the block. A level interrupt output follows one of the two flags, chosen by an interrupt-select input. The buffer-empty source stays silent until software has written at least one byte after reset.

Top module: `utxb_top`

## Requirements
- R1: After reset the control/status register reads 0x00, the serial line is high and the interrupt is low.
- R2: In the control/status register, bit 0 is enable, bit 1 is parity-on and bit 2 selects odd parity (0 = even). Writes to bits 3, 6 and 7 are ignored, and those bits read 0. The transmit-data register reads 0x00. Read data appears on the cycle after the read strobe.
- R3: With parity off, a frame is start (0), data bit 0 through data bit 7, then stop (1). The line changes only on bit-rate pulses, one bit per pulse.
- R4: With parity on, one parity bit follows data bit 7. Even parity sends the XOR of the data bits, and odd parity sends its inverse.
- R5: While enable is 0 the line stays high and no frame starts. A byte written while disabled is sent once enable is set.
- R6: Bit 4 (buffer-empty) reads 0 until a byte has been written after reset. A data write clears it. It sets again when the held byte moves into the shifter, which happens on the first bit-rate pulse at which the shifter is free.
- R7: A byte written while the holding register is full is discarded and never sent.
- R8: A held byte's start bit is sent on the pulse right after the previous stop bit, with no idle bit between frames.
- R9: Bit 5 (transmit-complete) sets on the pulse that ends a stop bit. It is cleared when a frame starts from an idle shifter, and it stays set across a back-to-back start.
- R10: A status read clears transmit-complete. If a frame ends in the same cycle as the read, the flag stays set.
- R11: The interrupt output equals buffer-empty when the interrupt-select input is 0 and transmit-complete when it is 1. It is updated in the same cycle as the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_sel | input | 1 | 0 = control/status register, 1 = transmit-data register |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Registered read data |
| bit_tick | input | 1 | One-cycle bit-rate enable pulse |
| irq_sel | input | 1 | Interrupt source: 0 = buffer-empty, 1 = transmit-complete |
| tx_line | output | 1 | Serial output, idles high |
| irq | output | 1 | Level interrupt |

## Verification
The assertions assume `bit_tick` is a single-cycle pulse and that read and write strobes never overlap. They also assume the strobes and `irq_sel` change only between clock edges. The bench drives every input on the falling edge, holds each strobe for exactly one cycle and never raises read and write together. Pulses are spaced apart so that register accesses fall between bits. A read and a frame end are made to coincide in the same cycle on purpose, to cover R10.

// File: rtl/utxb_pkg.sv
package utxb_pkg;
  localparam int FLAG_EMPTY_BIT = 4;
  localparam int FLAG_DONE_BIT  = 5;

  typedef struct packed {
    logic par_odd;
    logic par_en;
    logic en;
  } utxb_ctrl_t;

  localparam int CTRL_W = $bits(utxb_ctrl_t);
endpackage

// File: rtl/utxb_regs.sv
module utxb_regs
  import utxb_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_sel,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [DATA_W-1:0] wdata,
  input  logic              irq_sel,
  input  logic              load,
  input  logic              frame_done,
  output utxb_ctrl_t        ctrl,
  output logic [DATA_W-1:0] hold_data,
  output logic              hold_full,
  output logic [DATA_W-1:0] rdata,
  output logic              irq
);
  localparam int PAD_W = DATA_W - FLAG_DONE_BIT - 1;

  logic ever_written, done_q, empty_q;
  logic data_wr, ctrl_wr, stat_rd, wr_ok;
  logic full_n, ever_n, done_n, empty_n;
  logic [DATA_W-1:0] status_word;

  assign data_wr = wr_en && reg_sel;
  assign ctrl_wr = wr_en && !reg_sel;
  assign stat_rd = rd_en && !reg_sel;
  assign wr_ok   = data_wr && !hold_full;

  always_comb begin
    ever_n = ever_written | data_wr;
    if (wr_ok)     full_n = 1'b1;
    else if (load) full_n = 1'b0;
    else           full_n = hold_full;
    if (frame_done)          done_n = 1'b1;
    else if (stat_rd || load) done_n = 1'b0;
    else                     done_n = done_q;
    empty_n = ever_n && !full_n;
  end

  assign status_word = {{PAD_W{1'b0}}, done_q, empty_q, 1'b0, ctrl};

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl         <= '0;
      hold_data    <= '0;
      hold_full    <= 1'b0;
      ever_written <= 1'b0;
      done_q       <= 1'b0;
      empty_q      <= 1'b0;
      irq          <= 1'b0;
      rdata        <= '0;
    end else begin
      if (ctrl_wr) ctrl <= utxb_ctrl_t'(wdata[CTRL_W-1:0]);
      if (wr_ok)   hold_data <= wdata;
      hold_full    <= full_n;
      ever_written <= ever_n;
      done_q       <= done_n;
      empty_q      <= empty_n;
      irq          <= irq_sel ? done_n : empty_n;
      if (rd_en)   rdata <= reg_sel ? '0 : status_word;
    end
  end

  p_lost_write_r7: assert property (@(posedge clk) disable iff (rst)
    (data_wr && hold_full) |=> $stable(hold_data));
  p_read_clears_r10: assert property (@(posedge clk) disable iff (rst)
    (stat_rd && !frame_done) |=> !done_q);
  p_done_kept_r10: assert property (@(posedge clk) disable iff (rst)
    frame_done |=> done_q);
  p_quiet_irq_r6: assert property (@(posedge clk) disable iff (rst)
    (!ever_written && !irq_sel && !data_wr) |=> !irq);
  p_empty_after_load_r6: assert property (@(posedge clk) disable iff (rst)
    (load && !data_wr) |=> empty_q);
endmodule

// File: rtl/utxb_shifter.sv
module utxb_shifter
  import utxb_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  utxb_ctrl_t        ctrl,
  input  logic              bit_tick,
  input  logic              hold_full,
  input  logic [DATA_W-1:0] hold_data,
  output logic              load,
  output logic              frame_done,
  output logic              tx_line
);
  localparam int SR_W = DATA_W + 2;
  localparam int CW   = $clog2(SR_W + 1);
  localparam logic [CW-1:0] BITS_PLAIN  = CW'(DATA_W + 1);
  localparam logic [CW-1:0] BITS_PARITY = CW'(DATA_W + 2);

  logic            busy;
  logic [SR_W-1:0] sr;
  logic [CW-1:0]   rem;
  logic            par_bit, last_bit, shifting;
  logic [SR_W-1:0] frame;

  assign par_bit    = (^hold_data) ^ ctrl.par_odd;
  assign frame      = ctrl.par_en ? {1'b1, par_bit, hold_data} : {2'b11, hold_data};
  assign last_bit   = busy && (rem == '0);
  assign shifting   = busy && (rem != '0);
  assign frame_done = ctrl.en && bit_tick && last_bit;
  assign load       = ctrl.en && bit_tick && hold_full && !shifting;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      sr      <= '0;
      rem     <= '0;
      tx_line <= 1'b1;
    end else if (!ctrl.en) begin
      busy    <= 1'b0;
      rem     <= '0;
      tx_line <= 1'b1;
    end else if (bit_tick) begin
      if (shifting) begin
        tx_line <= sr[0];
        sr      <= {1'b1, sr[SR_W-1:1]};
        rem     <= rem - 1'b1;
      end else if (load) begin
        tx_line <= 1'b0;
        sr      <= frame;
        rem     <= ctrl.par_en ? BITS_PARITY : BITS_PLAIN;
        busy    <= 1'b1;
      end else begin
        busy    <= 1'b0;
        tx_line <= 1'b1;
      end
    end
  end

  p_idle_when_off_r5: assert property (@(posedge clk) disable iff (rst)
    !ctrl.en |=> tx_line);
  p_start_low_r3: assert property (@(posedge clk) disable iff (rst)
    load |=> !tx_line);
  p_stop_high_r3: assert property (@(posedge clk) disable iff (rst)
    frame_done |-> tx_line);
  p_line_on_tick_r3: assert property (@(posedge clk) disable iff (rst)
    (!bit_tick && ctrl.en) |=> $stable(tx_line));
endmodule

// File: rtl/utxb_top.sv
module utxb_top
  import utxb_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_sel,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic              bit_tick,
  input  logic              irq_sel,
  output logic              tx_line,
  output logic              irq
);
  utxb_ctrl_t        ctrl;
  logic [DATA_W-1:0] hold_data;
  logic              hold_full, load, frame_done;

  utxb_regs #(.DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst(rst), .reg_sel(reg_sel), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .irq_sel(irq_sel), .load(load), .frame_done(frame_done),
    .ctrl(ctrl), .hold_data(hold_data), .hold_full(hold_full),
    .rdata(rdata), .irq(irq)
  );

  utxb_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk(clk), .rst(rst), .ctrl(ctrl), .bit_tick(bit_tick),
    .hold_full(hold_full), .hold_data(hold_data),
    .load(load), .frame_done(frame_done), .tx_line(tx_line)
  );

  p_load_needs_byte_r6: assert property (@(posedge clk) disable iff (rst)
    load |-> hold_full);
endmodule

// File: tb/sim_utxb_top.sv
module sim_utxb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reg_sel = 1'b0, wr_en = 1'b0, rd_en = 1'b0, bit_tick = 1'b0, irq_sel = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic tx_line, irq;
  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  utxb_top #(.DATA_W(8)) u0 (
    .clk(clk), .rst(rst), .reg_sel(reg_sel), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .bit_tick(bit_tick), .irq_sel(irq_sel),
    .tx_line(tx_line), .irq(irq)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [7:0] d);
    @(negedge clk); reg_sel = sel; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic sel, output logic [7:0] d);
    @(negedge clk); reg_sel = sel; rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0; d = rdata;
  endtask

  task automatic tick();
    @(negedge clk); bit_tick = 1'b1;
    @(negedge clk); bit_tick = 1'b0;
  endtask

  // captures start, data, optional parity, stop; then one ending pulse
  task automatic run_frame(input logic pe, output logic [10:0] got);
    int n;
    n = pe ? 11 : 10;
    got = 11'h7FF;
    for (int i = 0; i < n; i++) begin
      tick();
      got[i] = tx_line;
    end
    tick();
  endtask

  function automatic logic [10:0] exp_frame(input logic [7:0] d, input logic pe, input logic po);
    logic p;
    p = (^d) ^ po;
    return pe ? {1'b1, p, d, 1'b0} : {2'b11, d, 1'b0};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] r;
    logic [10:0] got;
    logic [21:0] stream, exp_s;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1
    check("R1 line", tx_line, 1);
    check("R1 irq", irq, 0);
    rd(1'b0, r); check("R1 status", r, 8'h00);
    // R2
    wr(1'b0, 8'hFF);
    rd(1'b0, r); check("R2 reserved", r, 8'h07);
    rd(1'b1, r); check("R2 data reads 0", r, 8'h00);
    wr(1'b0, 8'h00);
    // R5 disabled, R6 quiet
    check("R6 quiet irq", irq, 0);
    wr(1'b1, 8'hA5);
    rd(1'b0, r); check("R6 empty cleared", r[4], 0);
    for (int i = 0; i < 3; i++) begin
      tick(); check("R5 idle line", tx_line, 1);
    end
    wr(1'b0, 8'h01);
    run_frame(1'b0, got); check("R5 sent after enable", got, exp_frame(8'hA5, 0, 0));
    check("R11 irq empty", irq, 1);
    rd(1'b0, r); check("R9 done set", r[5], 1);
    // sweep R3 R4 R9 R10
    for (int m = 0; m < 3; m++) begin
      logic pe, po;
      pe = (m != 0); po = (m == 2);
      wr(1'b0, {5'b0, po, pe, 1'b1});
      for (int b = 0; b < 256; b++) begin
        wr(1'b1, 8'(b));
        rd(1'b0, r); check("R6 write clears empty", r[4], 0);
        run_frame(pe, got);
        check(pe ? "R4 parity frame" : "R3 plain frame", got, exp_frame(8'(b), pe, po));
        rd(1'b0, r); check("R9 done and empty", r[5:4], 2'b11);
        rd(1'b0, r); check("R10 read cleared", r[5], 0);
      end
    end
    // R7 R8
    wr(1'b0, 8'h01);
    wr(1'b1, 8'h3C);
    tick(); check("R3 start A", tx_line, 0);
    wr(1'b1, 8'h5A);
    rd(1'b0, r); check("R6 full", r[4], 0);
    wr(1'b1, 8'hFF);
    for (int i = 0; i < 22; i++) begin
      tick(); stream[i] = tx_line;
    end
    exp_s = {4'hF, 8'h5A, 1'b0, 1'b1, 8'h3C};
    check("R8 R7 stream", stream, exp_s);
    rd(1'b0, r); check("R7 empty after", r[5:4], 2'b11);
    // R10 coincident read
    wr(1'b1, 8'h81);
    for (int i = 0; i < 10; i++) tick();
    @(negedge clk); bit_tick = 1'b1; rd_en = 1'b1; reg_sel = 1'b0;
    @(negedge clk); bit_tick = 1'b0; rd_en = 1'b0;
    rd(1'b0, r); check("R10 completion kept", r[5], 1);
    // R11 select
    wr(1'b1, 8'h42);
    run_frame(1'b0, got);
    irq_sel = 1'b1; @(negedge clk);
    check("R11 irq done", irq, 1);
    rd(1'b0, r); check("R11 irq after read", irq, 0);
    irq_sel = 1'b0; @(negedge clk);
    check("R11 irq back to empty", irq, 1);
    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule